// File: doc/BRIEF.md
# Grouped Interrupt Event and Mask Controller

This block holds the interrupt state of a network DMA engine. A 32-bit event register latches one-cycle event pulses from the datapath. A 32-bit mask register chooses which of those events may interrupt. The masked events are gathered into three level-sensitive, active-high lines: transmit, receive and error. Software clears an event by writing a 1 to its bit in the event register. It enables events by writing a new value to the mask register.

Each line is recomputed from the next register contents on every clock, so any change reaches the lines. That includes a new event, a clear, a mask write and reset. An event that arrived while masked therefore asserts its line as soon as its mask bit is set.

The block also finishes graceful stop requests for the receive and transmit directions. If the direction is idle when the request arrives, the stop-complete event is set at once. If the direction is busy, the request is held until the direction reports idle.

Top module: `irq_group_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the event register and the mask register read zero and all three lines are low. A reset in mid-run drops every line, whatever levels it had before.
- R2: A write to address 0 clears every event bit written as 1. Bits written as 0 keep their value.
- R3: A write to address 1 replaces the whole mask register with the written data.
- R4: Each line equals the OR, over its own group, of event AND mask. The line is registered and shows a change one clock after the write or pulse that caused it. This includes an event latched while masked and unmasked later.
- R5: The transmit line uses event bits 20 and 22 only. The receive line uses bits 7 and 15 only. The error line uses all 28 other bits, including 8, 23, 30 and 31.
- R6: A 1 on bit i of the event pulse input sets event bit i on the next clock. If a write-1-to-clear hits the same bit in the same cycle, the bit ends up set.
- R7: A receive stop request while the receive side is idle sets event bit 8 on the next clock. A transmit stop request while the transmit side is idle sets event bit 23 on the next clock.
- R8: A receive stop request while the receive side is busy is held pending. Event bit 8 is set on the clock after the first cycle in which the receive side reports idle, and the pending request is then dropped.
- R9: A transmit stop request while the transmit side is busy behaves the same way, using event bit 23 and the transmit idle input.
- R10: Read data shows the event register at address 0 and the mask register at address 1. Any other address reads zero. Writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (2) | Register address: 0 event, 1 mask |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| ev_pulse_i | input | 32 | One-cycle event pulses, one per event bit |
| rx_stop_req_i | input | 1 | Graceful receive stop request pulse |
| rx_idle_i | input | 1 | Receive side is idle |
| tx_stop_req_i | input | 1 | Graceful transmit stop request pulse |
| tx_idle_i | input | 1 | Transmit side is idle |
| irq_tx_o | output | 1 | Transmit interrupt line |
| irq_rx_o | output | 1 | Receive interrupt line |
| irq_err_o | output | 1 | Error interrupt line |

## Verification
The directed part covers four groups of cases:
- It sets events while the mask is open, and also while it is closed and later opened. This tells a design that recomputes the lines on a mask write from one that raises them only on new events.
- It pulses single bits at the group edges (7, 15, 20, 22, 3, 30) so that a bit routed to the wrong line shows.
- It clears and sets the same bit in one cycle to prove the set wins.
- It issues stop requests with the side idle and with the side busy, to separate completion at once from completion held over.

A long run of sparse random pulses, writes and requests then checks every cycle against the bench model. A reset in mid-run with lines high shows that no stale level survives reset.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int unsigned EV_W    = 32;
  localparam int unsigned NUM_GRP = 3;
  localparam int unsigned NUM_DIR = 2;

  typedef logic [EV_W-1:0] ev_vec_t;

  // bit positions the line grouping and stop completion depend on
  localparam int unsigned BIT_RX_FRM  = 7;
  localparam int unsigned BIT_RX_STOP = 8;
  localparam int unsigned BIT_RX_BUF  = 15;
  localparam int unsigned BIT_TX_FRM  = 20;
  localparam int unsigned BIT_TX_BUF  = 22;
  localparam int unsigned BIT_TX_STOP = 23;

  typedef enum logic [1:0] {GRP_TX = 2'd0, GRP_RX = 2'd1, GRP_ERR = 2'd2} grp_e;

  localparam ev_vec_t TX_GRP  = (ev_vec_t'(1) << BIT_TX_FRM) | (ev_vec_t'(1) << BIT_TX_BUF);
  localparam ev_vec_t RX_GRP  = (ev_vec_t'(1) << BIT_RX_FRM) | (ev_vec_t'(1) << BIT_RX_BUF);
  localparam ev_vec_t ERR_GRP = ~(TX_GRP | RX_GRP);

  function automatic ev_vec_t grp_bits(int unsigned g);
    case (g)
      0:       return TX_GRP;
      1:       return RX_GRP;
      default: return ERR_GRP;
    endcase
  endfunction

  // direction 0 = receive, 1 = transmit
  function automatic int unsigned stop_bit(int unsigned d);
    return (d == 0) ? BIT_RX_STOP : BIT_TX_STOP;
  endfunction
endpackage

// File: rtl/irq_evt_reg.sv
module irq_evt_reg
  import irq_grp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ev_vec_t set_i,
  input  ev_vec_t clr_i,
  output ev_vec_t ev_q_o,
  output ev_vec_t ev_d_o
);
  ev_vec_t ev_q, ev_d;
  logic    ev_en;

  always_comb begin
    ev_en = (|set_i) | (|clr_i);
    ev_d  = (ev_q & ~clr_i) | set_i;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= '0;
    else if (ev_en) ev_q <= ev_d;
  end

  assign ev_q_o = ev_q;
  assign ev_d_o = ev_d;

  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(clr_i & ~set_i)) == '0));
  p_w1c_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev_q & ~clr_i) & ~ev_q) == '0));
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ev_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irq_stop_ctrl.sv
module irq_stop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic idle_i,
  output logic done_o
);
  logic pend_q, pend_d, want;

  always_comb begin
    want   = req_i | pend_q;
    done_o = want & idle_i;
    pend_d = want & ~idle_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  p_done_only_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> idle_i);
  p_busy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !idle_i) |=> pend_q);
  p_pend_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !pend_q);
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen
  import irq_grp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ev_vec_t            ev_d_i,
  input  ev_vec_t            mask_d_i,
  output logic [NUM_GRP-1:0] irq_o
);
  ev_vec_t active;
  assign active = ev_d_i & mask_d_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
    localparam ev_vec_t GM = grp_bits(g);
    logic line_d, line_q;
    assign line_d = |(active & GM);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_d;
    end
    assign irq_o[g] = line_q;
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned EV_ADDR   = 0,
  parameter int unsigned MASK_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [EV_W-1:0]   reg_wdata_i,
  output logic [EV_W-1:0]   reg_rdata_o,
  input  logic [EV_W-1:0]   ev_pulse_i,
  input  logic              rx_stop_req_i,
  input  logic              rx_idle_i,
  input  logic              tx_stop_req_i,
  input  logic              tx_idle_i,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);
  localparam logic [ADDR_W-1:0] A_EV   = ADDR_W'(EV_ADDR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);

  logic               wr_ev, wr_mask;
  ev_vec_t            clr_vec, set_vec, stop_vec;
  ev_vec_t            ev_q, ev_d, mask_q, mask_d;
  logic [NUM_DIR-1:0] dir_req, dir_idle, dir_done;
  logic [NUM_GRP-1:0] lines;

  assign wr_ev   = reg_wr_i && (reg_addr_i == A_EV);
  assign wr_mask = reg_wr_i && (reg_addr_i == A_MASK);

  assign dir_req  = {tx_stop_req_i, rx_stop_req_i};
  assign dir_idle = {tx_idle_i, rx_idle_i};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_stop
    irq_stop_ctrl u_stop (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (dir_req[d]),
      .idle_i (dir_idle[d]),
      .done_o (dir_done[d])
    );
  end

  always_comb begin
    stop_vec = '0;
    for (int d = 0; d < NUM_DIR; d++) stop_vec[stop_bit(d)] = dir_done[d];
    set_vec  = ev_pulse_i | stop_vec;
    clr_vec  = wr_ev ? reg_wdata_i : '0;
    mask_d   = wr_mask ? reg_wdata_i : mask_q;
  end

  irq_evt_reg u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .ev_q_o (ev_q),
    .ev_d_o (ev_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= mask_d;
  end

  irq_line_gen u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_d_i   (ev_d),
    .mask_d_i (mask_d),
    .irq_o    (lines)
  );

  assign irq_tx_o  = lines[GRP_TX];
  assign irq_rx_o  = lines[GRP_RX];
  assign irq_err_o = lines[GRP_ERR];

  always_comb begin
    if (reg_addr_i == A_EV)        reg_rdata_o = ev_q;
    else if (reg_addr_i == A_MASK) reg_rdata_o = mask_q;
    else                           reg_rdata_o = '0;
  end

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata_i)));
  p_tx_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_o == (|(ev_q & mask_q & TX_GRP)));
  p_rx_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_o == (|(ev_q & mask_q & RX_GRP)));
  p_err_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err_o == (|(ev_q & mask_q & ERR_GRP)));
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |-> (!irq_tx_o && !irq_rx_o && !irq_err_o));
endmodule

// File: tb/irq_group_ctrl_tb_top.sv
module irq_group_ctrl_tb_top;
  localparam bit [31:0] TXM = 32'h0050_0000;
  localparam bit [31:0] RXM = 32'h0000_8080;
  localparam bit [31:0] ERM = 32'hFFAF_7F7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pulse = '0;
  logic        rx_req = 1'b0, rx_idle = 1'b1, tx_req = 1'b0, tx_idle = 1'b1;
  logic        irq_tx, irq_rx, irq_err;

  int    vecs = 0;
  int    bad  = 0;
  bit    chk_en = 1'b0;
  bit    done_flag = 1'b0;
  string cur = "R1";

  // behavioural reference state
  bit [31:0] m_ev, m_mask, m_clr, m_set;
  bit        m_tx, m_rx, m_err, m_rp, m_tp;

  always #5 clk = ~clk;

  irq_group_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ev_pulse_i(pulse),
    .rx_stop_req_i(rx_req), .rx_idle_i(rx_idle),
    .tx_stop_req_i(tx_req), .tx_idle_i(tx_idle),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ev = 0; m_mask = 0; m_tx = 0; m_rx = 0; m_err = 0; m_rp = 0; m_tp = 0;
    end else begin
      m_clr = (wr && addr == 2'd0) ? wdata : 32'h0;
      m_set = pulse;
      if ((rx_req || m_rp) && rx_idle) m_set[8] = 1'b1;
      m_rp = (rx_req || m_rp) && !rx_idle;
      if ((tx_req || m_tp) && tx_idle) m_set[23] = 1'b1;
      m_tp = (tx_req || m_tp) && !tx_idle;
      m_ev = (m_ev & ~m_clr) | m_set;
      if (wr && addr == 2'd1) m_mask = wdata;
      m_tx  = (m_ev & m_mask & TXM) != 0;
      m_rx  = (m_ev & m_mask & RXM) != 0;
      m_err = (m_ev & m_mask & ERM) != 0;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done_flag) begin
      cmp("irq_tx", {31'b0, irq_tx}, {31'b0, m_tx});
      cmp("irq_rx", {31'b0, irq_rx}, {31'b0, m_rx});
      cmp("irq_err", {31'b0, irq_err}, {31'b0, m_err});
      cmp("rdata", rdata, addr == 2'd0 ? m_ev : (addr == 2'd1 ? m_mask : 32'h0));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    wr = 1'b0; pulse = '0; rx_req = 1'b0; tx_req = 1'b0;
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    #2 rst_n = 1'b0;
    #1 chk_en = 1'b1;
    // R1: reset state, both registers read
    addr = 2'd0; @(posedge clk); #1; addr = 2'd1; @(posedge clk); #1;
    rst_n = 1'b1; addr = 2'd0; tick();

    cur = "R3";
    wreg(2'd1, 32'hFFFF_FFFF); tick();
    wreg(2'd1, 32'h0000_0080); tick();
    addr = 2'd1; tick();

    cur = "R5";
    wreg(2'd1, 32'hFFFF_FFFF); tick();
    addr = 2'd0;
    pulse = 32'h1 << 7;  tick(); tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();
    pulse = 32'h1 << 20; tick(); tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();
    pulse = 32'h1 << 3;  tick(); tick();
    pulse = 32'h1 << 30; tick();
    pulse = 32'h1 << 15; tick();
    pulse = 32'h1 << 22; tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();

    cur = "R4";
    wreg(2'd1, 32'h0); tick();
    addr = 2'd0;
    pulse = 32'h1 << 22; tick(); tick();
    wreg(2'd1, 32'h1 << 22); tick(); tick();
    wreg(2'd1, 32'h0); tick();
    wreg(2'd1, 32'h1 << 22); tick();

    cur = "R2";
    addr = 2'd0;
    pulse = 32'h0000_0009; tick();
    wreg(2'd0, 32'h0); tick();
    wreg(2'd0, 32'h1 << 22); tick();
    wreg(2'd0, 32'h1); tick();

    cur = "R6";
    wreg(2'd1, 32'hFFFF_FFFF); tick();
    wreg(2'd0, 32'h1 << 15); pulse = 32'h1 << 15; tick(); tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();

    cur = "R7";
    addr = 2'd0;
    rx_req = 1'b1; tick(); tick();
    tx_req = 1'b1; tick(); tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();

    cur = "R8";
    addr = 2'd0; rx_idle = 1'b0; rx_req = 1'b1; tick();
    tick(); tick(); tick();
    rx_idle = 1'b1; tick(); tick();
    wreg(2'd0, 32'hFFFF_FFFF); tick();

    cur = "R9";
    addr = 2'd0; tx_idle = 1'b0; tx_req = 1'b1; tick();
    tick(); tick();
    tx_idle = 1'b1; tick(); tick();

    cur = "R10";
    addr = 2'd2; tick();
    addr = 2'd3; tick();
    wreg(2'd3, 32'h0); tick();
    wreg(2'd2, 32'h1234_5678); tick();
    addr = 2'd0; tick();
    addr = 2'd1; tick();

    cur = "R4";
    for (int i = 0; i < 2000; i++) begin
      pulse   = $urandom & $urandom & $urandom;
      rx_idle = ($urandom % 4) != 0;
      tx_idle = ($urandom % 4) != 0;
      rx_req  = ($urandom % 16) == 0;
      tx_req  = ($urandom % 16) == 0;
      addr    = 2'($urandom % 4);
      if ($urandom % 5 == 0) begin
        wr    = 1'b1;
        wdata = ($urandom % 2) ? $urandom : ($urandom & $urandom);
      end
      @(posedge clk); #1;
      wr = 1'b0; pulse = '0; rx_req = 1'b0; tx_req = 1'b0;
    end

    cur = "R1";
    wreg(2'd1, 32'hFFFF_FFFF); pulse = 32'hFFFF_FFFF; tick(); tick();
    #2 rst_n = 1'b0;
    addr = 2'd0; @(posedge clk); #1; addr = 2'd1; @(posedge clk); #1;
    rst_n = 1'b1; tick(); tick();

    finish_run();
  end
endmodule